// File: doc/BRIEF.md
# UART Interrupt Prioritizer and Identification

This block gathers the interrupt causes of a UART, masks each one with its own bit in an enable register, and ranks what remains into a four-bit identification code in the 16550 style. It also drives a single interrupt request line. Receive line errors and modem status changes are latched until the matching status register is read. A character timeout is latched until fresh receive data is pushed. The receive-data-available and transmit-request causes follow level inputs from the FIFOs. Software reads the identification word to find the most urgent cause. That read also acknowledges a displayed transmit request.

The auto-baud lock indication sits beside the encoded field and never competes with it. The enable register also carries the line coding, unit and DMA enables. A write that would turn DMA on while either programmed-I/O data interrupt is enabled is refused, and a violation strobe is raised.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the enable register reads 0, the identification word reads 0x01 (apart from bit 4, which follows the auto-baud lock input), and `irq` and `dma_violation` are 0.
- R2: A write stores `reg_wdata[7:0]` in the enable register. Bit 0 is receive-data enable, 1 transmit-request enable, 2 line-status enable, 3 modem-status enable, 4 timeout enable, 5 line-coding enable, 6 unit enable and 7 DMA enable. The value reads back on `ier_rdata` from the next cycle, with bits 31 to 8 always 0.
- R3: `iir_rdata[3:0]` shows only the highest-ranked enabled pending cause. The ranking and codes are: line status 0110, receive data 0100, timeout 1100, transmit request 0010, modem status 0000.
- R4: `iir_rdata[0]` is 0 exactly when an enabled encoded cause is pending. When it is 1 the field reads 0001, and bits 31 to 5 always read 0.
- R5: `iir_rdata[4]` equals `src_abaud_lock` at all times. It is unaffected by, and does not affect, the encoded field.
- R6: A `src_rx_timeout` pulse latches the timeout cause. A `src_rx_push` pulse withdraws it in the next cycle, and push wins if both arrive together.
- R7: An `iir_rd` strobe while code 0010 is displayed hides the transmit request from the next cycle. It stays hidden while `src_tx_need` stays high and is re-armed once `src_tx_need` has been low for a cycle.
- R8: Line status and modem status causes are latched by their pulses and held until `clr_line` or `clr_modem`. A set and a clear in the same cycle leave the cause set.
- R9: A write with bit 7 set together with bit 0 or bit 1 is dropped entirely, and `dma_violation` is 1 for the following cycle only.
- R10: `irq` is 1 exactly when the unit enable is 1 and either an enabled encoded cause is pending or the auto-baud lock is high.
- R11: A cause whose enable bit is 0 is neither displayed nor asserted on `irq`. Latched causes stay latched and appear once enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_line_err | input | 1 | Receive line error pulse |
| src_rx_avail | input | 1 | Receive FIFO at or above trigger level |
| src_rx_timeout | input | 1 | Character timeout pulse |
| src_rx_push | input | 1 | New receive data arrived pulse |
| src_tx_need | input | 1 | Transmit FIFO below threshold |
| src_modem_chg | input | 1 | Modem status change pulse |
| src_abaud_lock | input | 1 | Auto-baud lock level |
| clr_line | input | 1 | Line status register read pulse |
| clr_modem | input | 1 | Modem status register read pulse |
| reg_wr_en | input | 1 | Enable register write strobe |
| reg_wdata | input | 32 | Enable register write data |
| ier_rdata | output | 32 | Enable register read data |
| iir_rd | input | 1 | Identification register read strobe |
| iir_rdata | output | 32 | Identification register read data |
| irq | output | 1 | Combined interrupt request |
| dma_violation | output | 1 | Refused DMA enable write strobe |

## Verification
The checker verifies the following on every cycle: the all-clear code whenever the pending bit is 1, the tracking of the auto-baud bit, the mutual exclusion of DMA and the data enables, the gating of `irq` by the unit enable, the withdrawal of a timeout after a push, the one-cycle violation strobe and the hiding of an acknowledged transmit request. Only the bench scenarios can show that the full ranking is right across all 32 cause combinations, and that a latched cause survives while disabled. They also show that the transmit request re-arms after its threshold input falls and rises again, and that a refused write leaves the earlier register value intact.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int REG_W  = 32;
    localparam int IER_W  = 8;
    localparam int CODE_W = 4;

    localparam int EN_RXAV  = 0;
    localparam int EN_TXRQ  = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;
    localparam int EN_TMO   = 4;
    localparam int EN_CODE  = 5;
    localparam int EN_UNIT  = 6;
    localparam int EN_DMA   = 7;

    localparam int ABL_BIT  = 4;

    localparam logic [CODE_W-1:0] ID_LINE  = 4'b0110;
    localparam logic [CODE_W-1:0] ID_RXAV  = 4'b0100;
    localparam logic [CODE_W-1:0] ID_TMO   = 4'b1100;
    localparam logic [CODE_W-1:0] ID_TXRQ  = 4'b0010;
    localparam logic [CODE_W-1:0] ID_MODEM = 4'b0000;
    localparam logic [CODE_W-1:0] ID_NONE  = 4'b0001;

    typedef struct packed {
        logic line;
        logic rxav;
        logic tmo;
        logic txrq;
        logic modem;
    } irq_src_t;
endpackage

// File: rtl/uart_irq_enreg.sv
module uart_irq_enreg
    import uart_irq_pkg::*;
#(
    parameter int DW = REG_W,
    parameter int EW = IER_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [EW-1:0] en_q,
    output logic          viol_q
);
    typedef struct packed {
        logic [EW-1:0] en;
        logic          viol;
    } en_state_t;

    en_state_t st_d, st_q;
    logic      bad_wr;

    always_comb begin
        st_d      = st_q;
        st_d.viol = 1'b0;
        bad_wr    = wdata[EN_DMA] & (wdata[EN_RXAV] | wdata[EN_TXRQ]);
        if (wr_en) begin
            if (bad_wr) st_d.viol = 1'b1;
            else        st_d.en   = wdata[EW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_q   = st_q.en;
    assign viol_q = st_q.viol;
endmodule

// File: rtl/uart_irq_srcs.sv
module uart_irq_srcs
    import uart_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     set_line,
    input  logic     clr_line,
    input  logic     set_modem,
    input  logic     clr_modem,
    input  logic     set_tmo,
    input  logic     rx_push,
    input  logic     rx_avail,
    input  logic     tx_need,
    input  logic     tx_ack,
    output irq_src_t pend
);
    typedef struct packed {
        logic line;
        logic modem;
        logic tmo;
        logic txack;
    } src_state_t;

    src_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_line)  st_d.line  = 1'b0;
        if (set_line)  st_d.line  = 1'b1;
        if (clr_modem) st_d.modem = 1'b0;
        if (set_modem) st_d.modem = 1'b1;
        if (set_tmo)   st_d.tmo   = 1'b1;
        if (rx_push)   st_d.tmo   = 1'b0;
        if (!tx_need)    st_d.txack = 1'b0;
        else if (tx_ack) st_d.txack = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        pend.line  = st_q.line;
        pend.rxav  = rx_avail;
        pend.tmo   = st_q.tmo;
        pend.txrq  = tx_need & ~st_q.txack;
        pend.modem = st_q.modem;
    end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  irq_src_t          req,
    output logic [CODE_W-1:0] code,
    output logic              any
);
    always_comb begin
        any = |req;
        if (req.line)       code = ID_LINE;
        else if (req.rxav)  code = ID_RXAV;
        else if (req.tmo)   code = ID_TMO;
        else if (req.txrq)  code = ID_TXRQ;
        else if (req.modem) code = ID_MODEM;
        else                code = ID_NONE;
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_line_err,
    input  logic             src_rx_avail,
    input  logic             src_rx_timeout,
    input  logic             src_rx_push,
    input  logic             src_tx_need,
    input  logic             src_modem_chg,
    input  logic             src_abaud_lock,
    input  logic             clr_line,
    input  logic             clr_modem,
    input  logic             reg_wr_en,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] ier_rdata,
    input  logic             iir_rd,
    output logic [REG_W-1:0] iir_rdata,
    output logic             irq,
    output logic             dma_violation
);
    logic [IER_W-1:0]  en_q;
    irq_src_t          pend, masked;
    logic [CODE_W-1:0] code;
    logic              any;
    logic              tx_ack;

    uart_irq_enreg #(.DW(REG_W), .EW(IER_W)) u_enreg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr_en),
        .wdata  (reg_wdata),
        .en_q   (en_q),
        .viol_q (dma_violation)
    );

    assign tx_ack = iir_rd & (code == ID_TXRQ);

    uart_irq_srcs u_srcs (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_line  (src_line_err),
        .clr_line  (clr_line),
        .set_modem (src_modem_chg),
        .clr_modem (clr_modem),
        .set_tmo   (src_rx_timeout),
        .rx_push   (src_rx_push),
        .rx_avail  (src_rx_avail),
        .tx_need   (src_tx_need),
        .tx_ack    (tx_ack),
        .pend      (pend)
    );

    always_comb begin
        masked.line  = pend.line  & en_q[EN_LINE];
        masked.rxav  = pend.rxav  & en_q[EN_RXAV];
        masked.tmo   = pend.tmo   & en_q[EN_TMO];
        masked.txrq  = pend.txrq  & en_q[EN_TXRQ];
        masked.modem = pend.modem & en_q[EN_MODEM];
    end

    uart_irq_prio u_prio (
        .req  (masked),
        .code (code),
        .any  (any)
    );

    always_comb begin
        ier_rdata                = '0;
        ier_rdata[IER_W-1:0]     = en_q;
        iir_rdata                = '0;
        iir_rdata[CODE_W-1:0]    = code;
        iir_rdata[ABL_BIT]       = src_abaud_lock;
        irq = en_q[EN_UNIT] & (any | src_abaud_lock);
    end
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk
    import uart_irq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             src_line_err,
    input logic             src_rx_avail,
    input logic             src_rx_timeout,
    input logic             src_rx_push,
    input logic             src_tx_need,
    input logic             src_modem_chg,
    input logic             src_abaud_lock,
    input logic             clr_line,
    input logic             clr_modem,
    input logic             reg_wr_en,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] ier_rdata,
    input logic             iir_rd,
    input logic [REG_W-1:0] iir_rdata,
    input logic             irq,
    input logic             dma_violation
);
    a_r4_idle_code: assert property (@(posedge clk) disable iff (!rst_n)
        iir_rdata[0] |-> (iir_rdata[3:0] == ID_NONE && iir_rdata[31:5] == '0));

    a_r5_abl_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        iir_rdata[ABL_BIT] == src_abaud_lock);

    a_r9_dma_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        ier_rdata[EN_DMA] |-> !(ier_rdata[EN_RXAV] || ier_rdata[EN_TXRQ]));

    a_r9_viol_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        dma_violation |=> !dma_violation || $past(reg_wr_en));

    a_r10_unit_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !ier_rdata[EN_UNIT] |-> !irq);

    a_r10_pending_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_rdata[EN_UNIT] && !iir_rdata[0]) |-> irq);

    a_r6_push_withdraws: assert property (@(posedge clk) disable iff (!rst_n)
        src_rx_push |=> iir_rdata[3:0] != ID_TMO);

    a_r7_tx_acked: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rd && iir_rdata[3:0] == ID_TXRQ && !reg_wr_en) |=> iir_rdata[3:0] != ID_TXRQ);

    a_r8_line_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (iir_rdata[3:0] == ID_LINE && !clr_line && !reg_wr_en) |=> iir_rdata[3:0] == ID_LINE);
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (.*);

// File: tb/tb_uart_irq_ident.sv
module tb_uart_irq_ident;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_line_err = 0, src_rx_avail = 0, src_rx_timeout = 0, src_rx_push = 0;
    logic        src_tx_need = 0, src_modem_chg = 0, src_abaud_lock = 0;
    logic        clr_line = 0, clr_modem = 0, reg_wr_en = 0, iir_rd = 0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] ier_rdata, iir_rdata;
    logic        irq, dma_violation;
    int          n_chk = 0, n_err = 0;
    bit          done = 0;

    always #10 clk = ~clk;

    uart_irq_ident dut (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] ref_code(logic [4:0] m);
        if (m[0])      return 4'b0110;
        else if (m[1]) return 4'b0100;
        else if (m[2]) return 4'b1100;
        else if (m[3]) return 4'b0010;
        else if (m[4]) return 4'b0000;
        return 4'b0001;
    endfunction

    task automatic write_ier(logic [31:0] v);
        @(negedge clk); reg_wr_en = 1; reg_wdata = v;
        @(negedge clk); reg_wr_en = 0; reg_wdata = '0;
    endtask

    task automatic clear_all();
        @(negedge clk);
        clr_line = 1; clr_modem = 1; src_rx_push = 1; src_tx_need = 0; src_rx_avail = 0;
        @(negedge clk);
        clr_line = 0; clr_modem = 0; src_rx_push = 0;
    endtask

    task automatic t_reset();
        check("R1 ier", ier_rdata, 32'h0);
        check("R1 iir", iir_rdata, 32'h1);
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 viol", {31'b0, dma_violation}, 32'h0);
    endtask

    task automatic t_ier_rw();
        write_ier(32'hFFFF_FF7C);
        check("R2 readback reserved zero", ier_rdata, 32'h7C);
        write_ier(32'h0000_0023);
        check("R2 readback", ier_rdata, 32'h23);
    endtask

    task automatic t_combos();
        write_ier(32'h5F);
        for (int m = 0; m < 32; m++) begin
            clear_all();
            src_line_err = m[0]; src_rx_avail = m[1]; src_rx_timeout = m[2];
            src_tx_need = m[3]; src_modem_chg = m[4];
            src_abaud_lock = ^m[4:0];
            @(negedge clk);
            src_line_err = 0; src_rx_timeout = 0; src_modem_chg = 0;
            check("R3 R4 code", {28'b0, iir_rdata[3:0]}, {28'b0, ref_code(m[4:0])});
            check("R5 abl bit", {31'b0, iir_rdata[4]}, {31'b0, ^m[4:0]});
            check("R10 irq", {31'b0, irq}, {31'b0, (m != 0) || (^m[4:0])});
        end
        src_abaud_lock = 0;
        clear_all();
    endtask

    task automatic t_abl();
        write_ier(32'h44);
        src_abaud_lock = 1; @(negedge clk);
        check("R5 abl idle", iir_rdata, 32'h11);
        check("R10 abl irq", {31'b0, irq}, 32'h1);
        src_line_err = 1; @(negedge clk); src_line_err = 0;
        check("R5 abl with line", iir_rdata, 32'h16);
        src_abaud_lock = 0; @(negedge clk);
        check("R5 abl drop", iir_rdata, 32'h06);
        write_ier(32'h04); src_abaud_lock = 1; @(negedge clk);
        check("R10 unit off", {31'b0, irq}, 32'h0);
        src_abaud_lock = 0;
        clear_all();
    endtask

    task automatic t_timeout();
        write_ier(32'h51);
        @(negedge clk); src_rx_timeout = 1;
        @(negedge clk); src_rx_timeout = 0;
        check("R6 timeout shown", {28'b0, iir_rdata[3:0]}, 32'hC);
        src_rx_push = 1; @(negedge clk); src_rx_push = 0;
        check("R6 timeout withdrawn", {28'b0, iir_rdata[3:0]}, 32'h1);
        src_rx_timeout = 1; src_rx_push = 1; @(negedge clk);
        src_rx_timeout = 0; src_rx_push = 0;
        check("R6 push wins", {28'b0, iir_rdata[3:0]}, 32'h1);
    endtask

    task automatic t_txack();
        write_ier(32'h46);
        src_tx_need = 1; @(negedge clk);
        check("R7 tx shown", {28'b0, iir_rdata[3:0]}, 32'h2);
        iir_rd = 1; @(negedge clk); iir_rd = 0;
        check("R7 tx acked", {28'b0, iir_rdata[3:0]}, 32'h1);
        check("R7 irq low", {31'b0, irq}, 32'h0);
        @(negedge clk);
        check("R7 still hidden", {28'b0, iir_rdata[3:0]}, 32'h1);
        src_tx_need = 0; @(negedge clk); src_tx_need = 1; @(negedge clk);
        check("R7 rearmed", {28'b0, iir_rdata[3:0]}, 32'h2);
        src_line_err = 1; @(negedge clk); src_line_err = 0;
        iir_rd = 1; @(negedge clk); iir_rd = 0;
        clr_line = 1; @(negedge clk); clr_line = 0;
        check("R7 no ack when not shown", {28'b0, iir_rdata[3:0]}, 32'h2);
        clear_all();
    endtask

    task automatic t_sticky();
        write_ier(32'h4C);
        src_modem_chg = 1; @(negedge clk); src_modem_chg = 0;
        repeat (3) @(negedge clk);
        check("R8 modem held", {28'b0, iir_rdata[3:0]}, 32'h0);
        src_line_err = 1; clr_line = 1; @(negedge clk); src_line_err = 0; clr_line = 0;
        check("R8 set beats clear", {28'b0, iir_rdata[3:0]}, 32'h6);
        clr_line = 1; @(negedge clk); clr_line = 0;
        check("R8 line cleared", {28'b0, iir_rdata[3:0]}, 32'h0);
        clr_modem = 1; @(negedge clk); clr_modem = 0;
        check("R8 modem cleared", {28'b0, iir_rdata[3:0]}, 32'h1);
    endtask

    task automatic t_dma();
        write_ier(32'h0);
        @(negedge clk); reg_wr_en = 1; reg_wdata = 32'h81;
        @(negedge clk); reg_wr_en = 0;
        check("R9 viol strobe", {31'b0, dma_violation}, 32'h1);
        check("R9 write dropped", ier_rdata, 32'h0);
        @(negedge clk);
        check("R9 viol one cycle", {31'b0, dma_violation}, 32'h0);
        write_ier(32'hC0);
        check("R9 dma alone ok", ier_rdata, 32'hC0);
        check("R9 no viol", {31'b0, dma_violation}, 32'h0);
        write_ier(32'hC2);
        check("R9 tie rejected", ier_rdata, 32'hC0);
    endtask

    task automatic t_disabled();
        write_ier(32'h40);
        src_line_err = 1; @(negedge clk); src_line_err = 0;
        check("R11 hidden", {28'b0, iir_rdata[3:0]}, 32'h1);
        check("R11 irq low", {31'b0, irq}, 32'h0);
        write_ier(32'h44);
        check("R11 appears when enabled", {28'b0, iir_rdata[3:0]}, 32'h6);
        clear_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_ier_rw();
        t_combos();
        t_abl();
        t_timeout();
        t_txack();
        t_sticky();
        t_dma();
        t_disabled();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule